// File: doc/BRIEF.md
# Masked interrupt status controller

This block keeps the interrupt status flags of a network controller together with the interrupt enable mask. It drives a single level-sensitive interrupt line toward the host. Event sources give one-cycle set pulses when something happens: a frame is received or sent, a frame fails, the receive buffer overruns, a host-side memory transfer finishes, or the controller is stopped. The block latches each pulse into its flag.

Software reads the status byte and writes ones to the flags it wants to acknowledge. It programs the mask to pick which flags may raise the line. Two external level vectors from the transmit and receive engines are merged into both the read value and the line decision. The line is recomputed from the next-state values and registered. It therefore rises or falls on the same clock edge that changes the status or the mask. This lets a host probe the line by enabling and then disabling a mask bit.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset the local status is 80h (only the stopped flag, bit 7, set), the mask is 00h and `irq_o` is 0.
- R2: A pulse on `set_pulse` bit 0 (receive ok), 1 (transmit ok), 2 (receive error), 3 (transmit error), 4 (overrun), 6 (transfer done) or 7 (stopped) sets that status bit at the next rising edge. Bit 5 is reserved: a pulse on it is ignored and the bit always reads 0 locally.
- R3: A status write with `stat_wr`=1 clears every bit among [6:0] where `stat_wdata` holds a 1. Bits written with 0 keep their value.
- R4: Bit 7 is never cleared by a status write. `start_cmd` clears bit 7 at the next edge. A stop pulse (`set_pulse[7]`) in the same cycle as `start_cmd` leaves bit 7 set.
- R5: When a set pulse and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R6: `stat_rdata` equals the local status OR `ext_tx_evt` OR `ext_rx_evt`, combinationally and with no clock delay.
- R7: `irq_o` is registered. After each rising edge it is 1 exactly when (local status | ext_tx_evt | ext_rx_evt) & mask & 7Fh, taken from the values in effect for that edge, is nonzero.
- R8: Bit 7 never raises `irq_o`, even when its mask bit is set.
- R9: A mask write takes effect on the line at the same edge that loads the mask. Clearing the mask drops `irq_o` at that edge.
- R10: An external event level raises `irq_o` at the first rising edge after it appears, when its bit is masked in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_pulse | input | 8 | One-cycle set requests, one per status bit |
| start_cmd | input | 1 | Start command, clears the stopped flag |
| ext_tx_evt | input | 8 | Transmit engine event levels merged into status |
| ext_rx_evt | input | 8 | Receive engine event levels merged into status |
| stat_wr | input | 1 | Status write strobe (write-one-to-clear) |
| stat_wdata | input | 8 | Status write data |
| stat_rdata | output | 8 | Merged status read value |
| mask_wr | input | 1 | Mask write strobe |
| mask_wdata | input | 8 | New mask value |
| irq_o | output | 1 | Registered interrupt line |

## Verification
Status flags, the mask and `irq_o` all change at the first rising edge after the stimulus cycle. None of them has an extra pipeline stage. The read port is the exception: it follows the external levels within the same cycle. The bench drives every input on the falling edge and samples 1 ns after the next rising edge. Each registered result is therefore checked in the cycle it is due. External-level read checks are sampled before any edge, which shows that they carry no delay.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int STAT_W   = 8;
    localparam int LINE_W   = 7;
    localparam int B_RX_OK  = 0;
    localparam int B_TX_OK  = 1;
    localparam int B_RX_ERR = 2;
    localparam int B_TX_ERR = 3;
    localparam int B_OVRUN  = 4;
    localparam int B_RSVD   = 5;
    localparam int B_XFER   = 6;
    localparam int B_STOP   = 7;

    localparam logic [STAT_W-1:0] LINE_MASK = STAT_W'((1 << LINE_W) - 1);
    localparam logic [STAT_W-1:0] SETTABLE  = ~(STAT_W'(1) << B_RSVD);
    localparam logic [STAT_W-1:0] CLEARABLE = LINE_MASK & SETTABLE;
    localparam logic [STAT_W-1:0] RST_VAL   = STAT_W'(1) << B_STOP;

    typedef struct packed {
        logic [STAT_W-1:0] bits;
    } bank_t;

    typedef struct packed {
        logic [STAT_W-1:0] mask;
        logic              irq;
    } line_t;
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
    parameter int                W        = irq_pkg::STAT_W,
    parameter logic [W-1:0]      SET_OK   = irq_pkg::SETTABLE,
    parameter logic [W-1:0]      CLR_OK   = irq_pkg::CLEARABLE,
    parameter logic [W-1:0]      RST_VAL  = irq_pkg::RST_VAL,
    parameter int                STOP_BIT = irq_pkg::B_STOP
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_pulse,
    input  logic         start_cmd,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] status_d,
    output logic [W-1:0] status_q
);
    irq_pkg::bank_t st_d, st_q;
    logic [W-1:0]   nxt;

    // Per-bit next value: set dominates clear; reserved bits stay low.
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic clr;
        if (i == STOP_BIT) begin : g_stop
            assign clr = start_cmd;
        end else begin : g_norm
            assign clr = wr_en & wdata[i] & CLR_OK[i];
        end
        if (SET_OK[i]) begin : g_live
            assign nxt[i] = set_pulse[i] | (st_q.bits[i] & ~clr);
        end else begin : g_dead
            assign nxt[i] = 1'b0;
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.bits = nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.bits <= RST_VAL;
        else        st_q      <= st_d;
    end

    assign status_d = st_d.bits;
    assign status_q = st_q.bits;

    assert_set_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & $past(set_pulse & SET_OK)) == $past(set_pulse & SET_OK)));

    assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((status_q & $past(wdata & CLR_OK & ~set_pulse)) == '0));

    assert_stop_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q[STOP_BIT] && !start_cmd) |=> status_q[STOP_BIT]);

    assert_start_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start_cmd && !set_pulse[STOP_BIT]) |=> !status_q[STOP_BIT]);
endmodule

// File: rtl/irq_line_gen.sv
module irq_line_gen #(
    parameter int           W        = irq_pkg::STAT_W,
    parameter logic [W-1:0] LINE_SEL = irq_pkg::LINE_MASK
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mask_wr,
    input  logic [W-1:0] mask_wdata,
    input  logic [W-1:0] status_d,
    input  logic [W-1:0] status_q,
    input  logic [W-1:0] ext_bits,
    output logic         irq_q
);
    irq_pkg::line_t ln_d, ln_q;

    // Line is decided from next-state status and mask so it moves with them.
    always_comb begin
        ln_d      = ln_q;
        if (mask_wr) ln_d.mask = mask_wdata;
        ln_d.irq  = |((status_d | ext_bits) & ln_d.mask & LINE_SEL);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ln_q.mask <= '0;
            ln_q.irq  <= 1'b0;
        end else begin
            ln_q <= ln_d;
        end
    end

    assign irq_q = ln_q.irq;

    assert_line_tracks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_q == |((status_q | $past(ext_bits)) & ln_q.mask & LINE_SEL)));
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl #(
    parameter int W = irq_pkg::STAT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_pulse,
    input  logic         start_cmd,
    input  logic [W-1:0] ext_tx_evt,
    input  logic [W-1:0] ext_rx_evt,
    input  logic         stat_wr,
    input  logic [W-1:0] stat_wdata,
    output logic [W-1:0] stat_rdata,
    input  logic         mask_wr,
    input  logic [W-1:0] mask_wdata,
    output logic         irq_o
);
    logic [W-1:0] status_d, status_q, ext_bits;

    assign ext_bits = ext_tx_evt | ext_rx_evt;

    irq_status_bank #(.W(W)) i_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_pulse(set_pulse),
        .start_cmd(start_cmd),
        .wr_en    (stat_wr),
        .wdata    (stat_wdata),
        .status_d (status_d),
        .status_q (status_q)
    );

    irq_line_gen #(.W(W)) i_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .mask_wr   (mask_wr),
        .mask_wdata(mask_wdata),
        .status_d  (status_d),
        .status_q  (status_q),
        .ext_bits  (ext_bits),
        .irq_q     (irq_o)
    );

    assign stat_rdata = status_q | ext_bits;

    assert_stop_no_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q | ext_bits) & irq_pkg::LINE_MASK) == '0 |=> !irq_o || $past(mask_wr) || $past(set_pulse != '0) || $past(ext_bits != '0));
endmodule

// File: tb/test_irq_status_ctrl.sv
module test_irq_status_ctrl;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] set_pulse, ext_tx_evt, ext_rx_evt, stat_wdata, mask_wdata, stat_rdata;
    logic       start_cmd, stat_wr, mask_wr, irq_o;
    int         n_chk = 0, n_err = 0;
    bit         done = 0;

    always #2 clk = ~clk;

    irq_status_ctrl i_irq_status_ctrl (
        .clk(clk), .rst_n(rst_n), .set_pulse(set_pulse), .start_cmd(start_cmd),
        .ext_tx_evt(ext_tx_evt), .ext_rx_evt(ext_rx_evt), .stat_wr(stat_wr),
        .stat_wdata(stat_wdata), .stat_rdata(stat_rdata), .mask_wr(mask_wr),
        .mask_wdata(mask_wdata), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Drive one cycle of stimulus on the falling edge, sample 1 ns after the rise.
    task automatic cyc(input logic [7:0] sp, input logic st, input logic sw,
                       input logic [7:0] swd, input logic mw, input logic [7:0] mwd);
        @(negedge clk);
        set_pulse = sp; start_cmd = st; stat_wr = sw; stat_wdata = swd;
        mask_wr = mw; mask_wdata = mwd;
        @(posedge clk);
        #1;
        set_pulse = '0; start_cmd = 0; stat_wr = 0; stat_wdata = '0;
        mask_wr = 0; mask_wdata = '0;
    endtask

    task automatic t_reset;
        chk("R1 status", stat_rdata, 8'h80);
        chk("R1 irq", {7'd0, irq_o}, 8'h00);
        cyc(8'h00, 0, 0, 8'h00, 1, 8'h7F); // mask all line bits
        chk("R1 mask was zero, status has no line bits", {7'd0, irq_o}, 8'h00);
        cyc(8'h00, 0, 0, 8'h00, 1, 8'h00);
    endtask

    task automatic t_set_each;
        logic [7:0] exp = 8'h80;
        for (int b = 0; b < 7; b++) begin
            cyc(8'(1 << b), 0, 0, 8'h00, 0, 8'h00);
            if (b != 5) exp = exp | 8'(1 << b);
            chk($sformatf("R2 set bit %0d", b), stat_rdata, exp);
        end
        cyc(8'hFF, 0, 1, 8'hFF, 0, 8'h00);
        chk("R5 all set win over clear", stat_rdata, 8'hDF);
        cyc(8'h00, 0, 1, 8'hFF, 0, 8'h00);
        chk("R3 clear all low bits, R4 bit7 stays", stat_rdata, 8'h80);
    endtask

    task automatic t_partial_clear;
        cyc(8'h1F, 0, 0, 8'h00, 0, 8'h00);
        cyc(8'h00, 0, 1, 8'h05, 0, 8'h00);
        chk("R3 partial clear", stat_rdata, 8'h9A);
        cyc(8'h08, 0, 1, 8'h0A, 0, 8'h00);
        chk("R5 set beats clear on bit3", stat_rdata, 8'h98);
        cyc(8'h00, 0, 1, 8'h7F, 0, 8'h00);
        chk("R3 cleanup", stat_rdata, 8'h80);
    endtask

    task automatic t_start_stop;
        cyc(8'h00, 0, 1, 8'h80, 0, 8'h00);
        chk("R4 write cannot clear bit7", stat_rdata, 8'h80);
        cyc(8'h00, 1, 0, 8'h00, 0, 8'h00);
        chk("R4 start clears bit7", stat_rdata, 8'h00);
        cyc(8'h80, 1, 0, 8'h00, 0, 8'h00);
        chk("R4 stop beats start", stat_rdata, 8'h80);
        cyc(8'h00, 1, 0, 8'h00, 0, 8'h00);
        chk("R4 start again", stat_rdata, 8'h00);
    endtask

    task automatic t_irq;
        cyc(8'h00, 0, 0, 8'h00, 1, 8'h02);
        chk("R9 mask only, no status", {7'd0, irq_o}, 8'h00);
        cyc(8'h02, 0, 0, 8'h00, 0, 8'h00);
        chk("R7 irq with pulse edge", {7'd0, irq_o}, 8'h01);
        cyc(8'h00, 0, 1, 8'h02, 0, 8'h00);
        chk("R7 irq drops on clear", {7'd0, irq_o}, 8'h00);
        cyc(8'h40, 0, 0, 8'h00, 0, 8'h00);
        chk("R7 unmasked bit6 quiet", {7'd0, irq_o}, 8'h00);
        cyc(8'h00, 0, 0, 8'h00, 1, 8'h40);
        chk("R9 mask enable raises line", {7'd0, irq_o}, 8'h01);
        cyc(8'h00, 0, 0, 8'h00, 1, 8'h00);
        chk("R9 mask clear drops line", {7'd0, irq_o}, 8'h00);
        cyc(8'h00, 0, 1, 8'h40, 0, 8'h00);
        cyc(8'h80, 0, 0, 8'h00, 1, 8'h80);
        chk("R8 bit7 masked gives no irq", {7'd0, irq_o}, 8'h00);
        chk("R8 bit7 held", stat_rdata, 8'h80);
        cyc(8'h00, 0, 0, 8'h00, 1, 8'h00);
    endtask

    task automatic t_ext;
        cyc(8'h00, 0, 0, 8'h00, 1, 8'h01);
        @(negedge clk);
        ext_rx_evt = 8'h01;
        ext_tx_evt = 8'h02;
        #0.5;
        chk("R6 read merges levels at once", stat_rdata, 8'h83);
        chk("R10 irq not yet", {7'd0, irq_o}, 8'h00);
        @(posedge clk);
        #1;
        chk("R10 ext raises irq one edge later", {7'd0, irq_o}, 8'h01);
        @(negedge clk);
        ext_rx_evt = 8'h00;
        ext_tx_evt = 8'h00;
        @(posedge clk);
        #1;
        chk("R10 ext drop lowers irq", {7'd0, irq_o}, 8'h00);
        chk("R6 local only", stat_rdata, 8'h80);
    endtask

    initial begin
        rst_n = 0; set_pulse = '0; start_cmd = 0; stat_wr = 0; stat_wdata = '0;
        mask_wr = 0; mask_wdata = '0; ext_tx_evt = '0; ext_rx_evt = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        t_reset();
        t_set_each();
        t_partial_clear();
        t_start_stop();
        t_irq();
        t_ext();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule